// File: doc/BRIEF.md
# Per-Channel DMA Register Window Translator

This block decodes a relocatable 64-byte I/O window that gives each DMA channel its own small register group. It turns accesses to that window into the equivalent operations on a legacy pair of cascaded 8237-style DMA controllers and their page registers. A base-group select decides whether the four relative channels of the window map to absolute channels 0–3 (low controller) or 4–7 (high controller).

The block holds the base and current address and the base and current count for every absolute channel, plus a page byte. Page, command, mode, mask and similar accesses are re-issued as legacy I/O cycles on a single valid/ready request port. A status read goes out on the same port as a legacy read, and the block returns the byte that comes back. Two mask operations have no single legacy equivalent and are built from legacy writes: clear-all-masks and set-one-mask-from-a-bit.

Top module: `ddma_xlate`

## Requirements
- R1: An access hits only when `win_base[15:6]` is non-zero and equals `reg_addr[15:6]`; bits `win_base[5:0]` are ignored. A write that misses changes no storage and sends no legacy request, and a read that misses returns no `reg_rvalid`.
- R2: `reg_addr[5:4]` is the relative channel and `reg_addr[3:0]` the register offset. The absolute channel is the relative channel plus 4 when `hi_group` is 1, and each absolute channel has its own storage.
- R3: Writes to offset 0 and 1 set the low and high byte of the base address and copy the whole base address into the current address. Reads of offset 0 and 1 return the low and high byte of the current address.
- R4: Writes to offset 4 and 5 set the low and high byte of the base count and copy it into the current count. Reads of offset 4 and 5 return the low and high byte of the current count.
- R5: A write to offset 2 stores the page byte and sends one legacy write with the same data to address 0x80 (low group) or 0x88 (high group) plus 7, 3, 1 or 2 for relative channel 0, 1, 2 or 3. A read of offset 2 returns the stored page byte.
- R6: A write to offset 0x8, 0x9, 0xA, 0xB or 0xD sends one legacy write with the same data to the controller base plus that offset. The controller base is 0x00 in the low group and 0xC0 in the high group.
- R7: A write to offset 0xE sends four legacy writes to controller base plus 0xA, with data 0x00, 0x01, 0x02 and 0x03, in that order.
- R8: A write to offset 0xF sends one legacy write to controller base plus 0xA, with data equal to the written byte shifted left by 2, truncated to 8 bits, OR the relative channel number.
- R9: A read of offset 9 sends a legacy read (`leg_write` = 0) to controller base plus 0x8. The byte on `leg_rdata` when `leg_rvalid` is high is returned on `reg_rdata` with `reg_rvalid` in the next cycle, and never in the cycle right after the read is accepted.
- R10: Reads of offsets 3, 6, 7, 8 and 0xA to 0xF return 0xFF. Writes to offsets 3, 6, 7 and 0xC change no storage and send no legacy request.
- R11: `reg_ready` is low from the cycle after a forwarded access is accepted until its last legacy cycle (and, for a status read, its response) has completed. Strobes seen while `reg_ready` is low are ignored.
- R12: While `leg_valid` is high and `leg_ready` is low, `leg_valid`, `leg_write`, `leg_addr` and `leg_wdata` hold their values.
- R13: Synchronous active-high `rst` clears all address, count and page storage to zero. A non-status read returns `reg_rdata` with a one-cycle `reg_rvalid` pulse in the cycle after the read strobe is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| win_base | input | 16 | Window base; bits 5:0 ignored, zero disables |
| hi_group | input | 1 | 0: channels 0–3, 1: channels 4–7 |
| reg_addr | input | 16 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_ready | output | 1 | High when a strobe can be accepted |
| reg_rvalid | output | 1 | Read data valid pulse |
| reg_rdata | output | 8 | Read data |
| leg_valid | output | 1 | Legacy request valid |
| leg_ready | input | 1 | Legacy request accepted |
| leg_write | output | 1 | 1: legacy write, 0: legacy read |
| leg_addr | output | 16 | Legacy I/O address |
| leg_wdata | output | 8 | Legacy write data |
| leg_rvalid | input | 1 | Legacy read response valid |
| leg_rdata | input | 8 | Legacy read response data |

## Verification
Local reads are due exactly one cycle after the accepting edge, so the bench counts falling edges from acceptance and expects the first one to show `reg_rvalid`. A status read is due one cycle after the bench's own responder raises `leg_rvalid`, which itself follows the legacy handshake by a cycle, so the bench waits for `reg_rvalid` and also checks that it was not early. Legacy cycles are logged at the falling edge before each handshake edge and compared only once `reg_ready` has returned high, so the four-beat burst and the stalled request are checked in order and in full.

// File: rtl/ddma_pkg.sv
package ddma_pkg;

    localparam int ADDR_W    = 16;
    localparam int LEG_W     = 16;
    localparam int WIN_LSB   = 6;
    localparam int GRP_CH    = 4;
    localparam int NUM_CH    = 2 * GRP_CH;
    localparam int BURST_LEN = 4;

    // register offsets inside one channel group
    localparam logic [3:0] OFS_ADDR_LO = 4'h0;
    localparam logic [3:0] OFS_ADDR_HI = 4'h1;
    localparam logic [3:0] OFS_PAGE    = 4'h2;
    localparam logic [3:0] OFS_CNT_LO  = 4'h4;
    localparam logic [3:0] OFS_CNT_HI  = 4'h5;
    localparam logic [3:0] OFS_STATUS  = 4'h9;
    localparam logic [3:0] OFS_UNMASK  = 4'hE;
    localparam logic [3:0] OFS_MASK1   = 4'hF;

    // legacy controller register offsets
    localparam logic [3:0] LEG_STAT    = 4'h8;
    localparam logic [3:0] LEG_SMASK   = 4'hA;

    typedef struct packed {
        logic       hit;
        logic [2:0] ch;
        logic [1:0] rel;
        logic [3:0] off;
    } dec_t;

    typedef struct packed {
        logic             write;
        logic [LEG_W-1:0] addr;
        logic [7:0]       data;
    } leg_req_t;

    typedef enum logic [1:0] {
        FW_IDLE,
        FW_SEND,
        FW_WAIT
    } fwd_state_e;

    function automatic logic [2:0] page_slot(input logic [1:0] rel);
        case (rel)
            2'd0:    return 3'd7;
            2'd1:    return 3'd3;
            2'd2:    return 3'd1;
            default: return 3'd2;
        endcase
    endfunction

    function automatic logic [LEG_W-1:0] ctrl_addr(input logic hi, input logic [3:0] off);
        return (hi ? LEG_W'(16'h00C0) : LEG_W'(16'h0000)) | LEG_W'(off);
    endfunction

    function automatic logic [LEG_W-1:0] page_addr(input logic hi, input logic [1:0] rel);
        return LEG_W'(16'h0080) + (hi ? LEG_W'(8) : LEG_W'(0)) + LEG_W'(page_slot(rel));
    endfunction

    function automatic logic is_passthru(input logic [3:0] off);
        return (off == 4'h8) || (off == 4'h9) || (off == 4'hA) ||
               (off == 4'hB) || (off == 4'hD);
    endfunction

    function automatic logic is_local(input logic [3:0] off);
        return (off == OFS_ADDR_LO) || (off == OFS_ADDR_HI) || (off == OFS_PAGE) ||
               (off == OFS_CNT_LO)  || (off == OFS_CNT_HI);
    endfunction

endpackage

// File: rtl/ddma_decode.sv
module ddma_decode
    import ddma_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] win_base,
    input  logic          hi_group,
    output dec_t          dec
);
    logic base_on;

    always_comb begin
        base_on  = |win_base[AW-1:WIN_LSB];
        dec.hit  = base_on && (addr[AW-1:WIN_LSB] == win_base[AW-1:WIN_LSB]);
        dec.rel  = addr[5:4];
        dec.off  = addr[3:0];
        dec.ch   = {hi_group, addr[5:4]};
    end
endmodule

// File: rtl/ddma_chan_regs.sv
module ddma_chan_regs
    import ddma_pkg::*;
#(
    parameter int NCH = NUM_CH
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   we,
    input  logic [$clog2(NCH)-1:0] wch,
    input  logic [3:0]             woff,
    input  logic [7:0]             wd,
    input  logic [$clog2(NCH)-1:0] rch,
    output logic [15:0]            cur_addr,
    output logic [15:0]            cur_cnt,
    output logic [7:0]             page
);
    localparam int CW = $clog2(NCH);

    logic [NCH-1:0][15:0] ca_all;
    logic [NCH-1:0][15:0] cc_all;
    logic [NCH-1:0][7:0]  pg_all;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic [15:0] base_a, cur_a, base_c, cur_c;
        logic [7:0]  pg;
        logic        sel;

        assign sel = we && (wch == CW'(c));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_a <= '0;
                cur_a  <= '0;
                base_c <= '0;
                cur_c  <= '0;
                pg     <= '0;
            end else if (sel) begin
                case (woff)
                    OFS_ADDR_LO: begin
                        base_a <= {base_a[15:8], wd};
                        cur_a  <= {base_a[15:8], wd};
                    end
                    OFS_ADDR_HI: begin
                        base_a <= {wd, base_a[7:0]};
                        cur_a  <= {wd, base_a[7:0]};
                    end
                    OFS_CNT_LO: begin
                        base_c <= {base_c[15:8], wd};
                        cur_c  <= {base_c[15:8], wd};
                    end
                    OFS_CNT_HI: begin
                        base_c <= {wd, base_c[7:0]};
                        cur_c  <= {wd, base_c[7:0]};
                    end
                    OFS_PAGE: pg <= wd;
                    default: ;
                endcase
            end
        end

        assign ca_all[c] = cur_a;
        assign cc_all[c] = cur_c;
        assign pg_all[c] = pg;
    end

    assign cur_addr = ca_all[rch];
    assign cur_cnt  = cc_all[rch];
    assign page     = pg_all[rch];

    AST_ADDR_LO_COPY: assert property (@(posedge clk) disable iff (rst)
        (we && woff == OFS_ADDR_LO) |=> ca_all[$past(wch)][7:0] == $past(wd)); // R3
    AST_CNT_HI_COPY: assert property (@(posedge clk) disable iff (rst)
        (we && woff == OFS_CNT_HI) |=> cc_all[$past(wch)][15:8] == $past(wd)); // R4
endmodule

// File: rtl/ddma_fwd.sv
module ddma_fwd
    import ddma_pkg::*;
#(
    parameter int BLEN = BURST_LEN
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  leg_req_t         start_req,
    input  logic             start_burst,
    output logic             busy,
    output logic             leg_valid,
    input  logic             leg_ready,
    output logic             leg_write,
    output logic [LEG_W-1:0] leg_addr,
    output logic [7:0]       leg_wdata,
    input  logic             leg_rvalid,
    input  logic [7:0]       leg_rdata,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data
);
    localparam int BW = $clog2(BLEN);
    localparam logic [BW-1:0] LAST = BW'(BLEN - 1);

    fwd_state_e  state;
    leg_req_t    req;
    logic        burst;
    logic [BW-1:0] beat;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= FW_IDLE;
            req   <= '0;
            burst <= 1'b0;
            beat  <= '0;
        end else begin
            case (state)
                FW_IDLE: if (start) begin
                    req   <= start_req;
                    burst <= start_burst;
                    beat  <= '0;
                    state <= FW_SEND;
                end
                FW_SEND: if (leg_ready) begin
                    if (!req.write) begin
                        state <= FW_WAIT;
                    end else if (burst && beat != LAST) begin
                        beat     <= beat + 1'b1;
                        req.data <= 8'(beat + 1'b1);
                    end else begin
                        state <= FW_IDLE;
                    end
                end
                FW_WAIT: if (leg_rvalid) state <= FW_IDLE;
                default: state <= FW_IDLE;
            endcase
        end
    end

    assign busy      = (state != FW_IDLE);
    assign leg_valid = (state == FW_SEND);
    assign leg_write = req.write;
    assign leg_addr  = req.addr;
    assign leg_wdata = req.data;
    assign rsp_valid = (state == FW_WAIT) && leg_rvalid;
    assign rsp_data  = leg_rdata;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (leg_valid && !leg_ready) |=> (leg_valid && $stable(leg_addr) &&
                                       $stable(leg_wdata) && $stable(leg_write))); // R12
    AST_BURST_STEP: assert property (@(posedge clk) disable iff (rst)
        (leg_valid && leg_ready && burst && beat != LAST) |=>
            (leg_valid && leg_wdata == $past(leg_wdata) + 8'd1 && leg_addr == $past(leg_addr))); // R7
endmodule

// File: rtl/ddma_xlate.sv
module ddma_xlate
    import ddma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] win_base,
    input  logic        hi_group,
    input  logic [15:0] reg_addr,
    input  logic [7:0]  reg_wdata,
    input  logic        reg_wr,
    input  logic        reg_rd,
    output logic        reg_ready,
    output logic        reg_rvalid,
    output logic [7:0]  reg_rdata,
    output logic        leg_valid,
    input  logic        leg_ready,
    output logic        leg_write,
    output logic [15:0] leg_addr,
    output logic [7:0]  leg_wdata,
    input  logic        leg_rvalid,
    input  logic [7:0]  leg_rdata
);
    dec_t        dec;
    logic        busy;
    logic        wr_acc, rd_acc;
    logic        fwd_start, fwd_burst;
    leg_req_t    fwd_req;
    logic [15:0] cur_addr, cur_cnt;
    logic [7:0]  page;
    logic [7:0]  local_rd;
    logic        rsp_valid;
    logic [7:0]  rsp_data;

    ddma_decode #(.AW(ADDR_W)) u_dec (
        .addr     (reg_addr),
        .win_base (win_base),
        .hi_group (hi_group),
        .dec      (dec)
    );

    assign reg_ready = !busy;
    assign wr_acc    = reg_wr && reg_ready && dec.hit;
    assign rd_acc    = reg_rd && !reg_wr && reg_ready && dec.hit;

    ddma_chan_regs #(.NCH(NUM_CH)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .we       (wr_acc && is_local(dec.off)),
        .wch      (dec.ch),
        .woff     (dec.off),
        .wd       (reg_wdata),
        .rch      (dec.ch),
        .cur_addr (cur_addr),
        .cur_cnt  (cur_cnt),
        .page     (page)
    );

    // classify the accepted access into a legacy request
    always_comb begin
        fwd_start     = 1'b0;
        fwd_burst     = 1'b0;
        fwd_req.write = 1'b1;
        fwd_req.addr  = ctrl_addr(dec.ch[2], dec.off);
        fwd_req.data  = reg_wdata;
        if (rd_acc && dec.off == OFS_STATUS) begin
            fwd_start     = 1'b1;
            fwd_req.write = 1'b0;
            fwd_req.addr  = ctrl_addr(dec.ch[2], LEG_STAT);
            fwd_req.data  = '0;
        end else if (wr_acc) begin
            if (dec.off == OFS_PAGE) begin
                fwd_start    = 1'b1;
                fwd_req.addr = page_addr(dec.ch[2], dec.rel);
            end else if (is_passthru(dec.off)) begin
                fwd_start    = 1'b1;
            end else if (dec.off == OFS_UNMASK) begin
                fwd_start    = 1'b1;
                fwd_burst    = 1'b1;
                fwd_req.addr = ctrl_addr(dec.ch[2], LEG_SMASK);
                fwd_req.data = '0;
            end else if (dec.off == OFS_MASK1) begin
                fwd_start    = 1'b1;
                fwd_req.addr = ctrl_addr(dec.ch[2], LEG_SMASK);
                fwd_req.data = {reg_wdata[5:0], dec.rel};
            end
        end
    end

    ddma_fwd #(.BLEN(BURST_LEN)) u_fwd (
        .clk         (clk),
        .rst         (rst),
        .start       (fwd_start),
        .start_req   (fwd_req),
        .start_burst (fwd_burst),
        .busy        (busy),
        .leg_valid   (leg_valid),
        .leg_ready   (leg_ready),
        .leg_write   (leg_write),
        .leg_addr    (leg_addr),
        .leg_wdata   (leg_wdata),
        .leg_rvalid  (leg_rvalid),
        .leg_rdata   (leg_rdata),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data)
    );

    always_comb begin
        case (dec.off)
            OFS_ADDR_LO: local_rd = cur_addr[7:0];
            OFS_ADDR_HI: local_rd = cur_addr[15:8];
            OFS_PAGE:    local_rd = page;
            OFS_CNT_LO:  local_rd = cur_cnt[7:0];
            OFS_CNT_HI:  local_rd = cur_cnt[15:8];
            default:     local_rd = 8'hFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rvalid <= 1'b0;
            reg_rdata  <= '0;
        end else begin
            reg_rvalid <= 1'b0;
            if (rd_acc && dec.off != OFS_STATUS) begin
                reg_rvalid <= 1'b1;
                reg_rdata  <= local_rd;
            end else if (rsp_valid) begin
                reg_rvalid <= 1'b1;
                reg_rdata  <= rsp_data;
            end
        end
    end

    AST_MISS_SILENT: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_ready && win_base[15:6] == 10'd0) |=> !reg_rvalid); // R1
    AST_LOCAL_RD_LAT: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && dec.off != OFS_STATUS) |=> reg_rvalid); // R13
    AST_UNDEF_FF: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && !is_local(dec.off) && dec.off != OFS_STATUS) |=> reg_rdata == 8'hFF); // R10
    AST_STATUS_NOT_EARLY: assert property (@(posedge clk) disable iff (rst)
        (rd_acc && dec.off == OFS_STATUS) |=> !reg_rvalid); // R9
    AST_BUSY_AFTER_FWD: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_ready && dec.hit && dec.off == OFS_UNMASK) |=> !reg_ready); // R11
endmodule

// File: tb/ddma_xlate_test.sv
module ddma_xlate_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] win_base = 16'h1240;
    logic        hi_group = 1'b0;
    logic [15:0] reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic        reg_ready, reg_rvalid;
    logic [7:0]  reg_rdata;
    logic        leg_valid, leg_write;
    logic        lg_ready = 1'b1;
    logic [15:0] leg_addr;
    logic [7:0]  leg_wdata;
    logic        leg_rvalid = 1'b0;
    logic [7:0]  leg_rdata = '0;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    ddma_xlate uut (
        .clk(clk), .rst(rst), .win_base(win_base), .hi_group(hi_group),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_ready(reg_ready), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .leg_valid(leg_valid), .leg_ready(lg_ready), .leg_write(leg_write),
        .leg_addr(leg_addr), .leg_wdata(leg_wdata),
        .leg_rvalid(leg_rvalid), .leg_rdata(leg_rdata)
    );

    // legacy side: log handshakes, answer reads one cycle later with 0xA5
    logic [15:0] log_addr [16];
    logic [7:0]  log_data [16];
    logic        log_wr   [16];
    int log_n   = 0;
    int rd_seen = 0;
    int rd_done = 0;

    always @(negedge clk) begin
        if (leg_valid && lg_ready) begin
            if (log_n < 16) begin
                log_addr[log_n] = leg_addr;
                log_data[log_n] = leg_wdata;
                log_wr[log_n]   = leg_write;
            end
            log_n = log_n + 1;
            if (!leg_write) rd_seen = rd_seen + 1;
        end
    end

    always @(posedge clk) begin
        #1;
        if (rd_seen != rd_done) begin
            leg_rvalid = 1'b1;
            leg_rdata  = 8'hA5;
            rd_done    = rd_done + 1;
        end else begin
            leg_rvalid = 1'b0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] wa(input logic [1:0] rel, input logic [3:0] off);
        return 16'h1240 | {10'd0, rel, off};
    endfunction

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        while (!reg_ready) begin @(posedge clk); #1; end
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [7:0] d, output int lat);
        @(posedge clk); #1;
        while (!reg_ready) begin @(posedge clk); #1; end
        reg_addr = a; reg_rd = 1'b1;
        @(posedge clk); #1;
        reg_rd = 1'b0;
        lat = 0; d = 8'h00;
        for (int i = 1; i <= 12; i++) begin
            @(negedge clk);
            if (reg_rvalid) begin lat = i; d = reg_rdata; break; end
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (reg_ready && !leg_valid) break;
        end
    endtask

    // {hi, 1'b0, rel, off, 8'h00, wdata, expected readback}
    localparam logic [31:0] VEC [0:8] = '{
        {1'b0, 1'b0, 2'd0, 4'h0, 8'h00, 8'h34, 8'h34},
        {1'b0, 1'b0, 2'd0, 4'h1, 8'h00, 8'h12, 8'h12},
        {1'b0, 1'b0, 2'd1, 4'h4, 8'h00, 8'h78, 8'h78},
        {1'b0, 1'b0, 2'd1, 4'h5, 8'h00, 8'h56, 8'h56},
        {1'b1, 1'b0, 2'd2, 4'h0, 8'h00, 8'hAB, 8'hAB},
        {1'b1, 1'b0, 2'd3, 4'h5, 8'h00, 8'hCD, 8'hCD},
        {1'b0, 1'b0, 2'd2, 4'h2, 8'h00, 8'h5A, 8'h5A},
        {1'b0, 1'b0, 2'd3, 4'h3, 8'h00, 8'h99, 8'hFF},
        {1'b1, 1'b0, 2'd0, 4'h6, 8'h00, 8'h11, 8'hFF}
    };

    initial begin
        #(8 * 200000);
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0]  d;
        int          lat;
        logic [15:0] held_a;

        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R13: storage cleared, one-cycle read latency
        @(negedge clk);
        check("R13 ready after reset", {31'd0, reg_ready}, 1);
        check("R13 no request after reset", {31'd0, leg_valid}, 0);
        do_read(wa(2'd0, 4'h0), d, lat);
        check("R13 addr zero", d, 0);
        check("R13 latency", lat, 1);
        do_read(wa(2'd1, 4'h5), d, lat);
        check("R13 count zero", d, 0);
        do_read(wa(2'd3, 4'h2), d, lat);
        check("R13 page zero", d, 0);

        // table walk: R3 R4 R5 R10 R2
        foreach (VEC[i]) begin
            hi_group = VEC[i][31];
            do_write(wa(VEC[i][29:28], VEC[i][27:24]), VEC[i][15:8]);
            wait_idle();
            do_read(wa(VEC[i][29:28], VEC[i][27:24]), d, lat);
            check($sformatf("R3/R4/R5/R10 vector %0d", i), {lat[7:0], d}, {8'd1, VEC[i][7:0]});
        end

        // R2: groups are separate storage
        hi_group = 1'b1;
        do_read(wa(2'd0, 4'h0), d, lat);
        check("R2 channel 4 untouched", d, 8'h00);
        hi_group = 1'b0;
        do_read(wa(2'd0, 4'h1), d, lat);
        check("R2 channel 0 high byte", d, 8'h12);
        do_read(wa(2'd2, 4'h0), d, lat);
        check("R2 channel 2 untouched", d, 8'h00);

        // R5: page forward addresses
        log_n = 0; hi_group = 1'b1;
        do_write(wa(2'd1, 4'h2), 8'h3C);
        wait_idle();
        check("R5 high page forward", {log_n[7:0], log_wr[0], log_addr[0], log_data[0]},
              {8'd1, 1'b1, 16'h008B, 8'h3C});
        log_n = 0; hi_group = 1'b0;
        do_write(wa(2'd0, 4'h2), 8'h21);
        wait_idle();
        check("R5 low page forward", {log_n[7:0], log_wr[0], log_addr[0], log_data[0]},
              {8'd1, 1'b1, 16'h0087, 8'h21});

        // R6: passthrough
        log_n = 0;
        do_write(wa(2'd2, 4'hB), 8'h46);
        wait_idle();
        hi_group = 1'b1;
        do_write(wa(2'd0, 4'hD), 8'h00);
        wait_idle();
        do_write(wa(2'd3, 4'h8), 8'h10);
        wait_idle();
        check("R6 count", log_n, 3);
        check("R6 low mode", {log_addr[0], log_data[0]}, {16'h000B, 8'h46});
        check("R6 high clear", {log_addr[1], log_data[1]}, {16'h00CD, 8'h00});
        check("R6 high command", {log_addr[2], log_data[2]}, {16'h00C8, 8'h10});

        // R7 + R11: unmask-all burst
        log_n = 0; hi_group = 1'b0;
        do_write(wa(2'd1, 4'hE), 8'hFF);
        check("R11 ready low during burst", {31'd0, reg_ready}, 0);
        wait_idle();
        check("R7 beat count", log_n, 4);
        for (int k = 0; k < 4; k++)
            check($sformatf("R7 beat %0d", k), {log_addr[k], log_data[k]}, {16'h000A, 8'(k)});

        // R8: single mask
        log_n = 0; hi_group = 1'b1;
        do_write(wa(2'd3, 4'hF), 8'h41);
        wait_idle();
        check("R8 mask one", {log_n[7:0], log_addr[0], log_data[0]}, {8'd1, 16'h00CA, 8'h07});

        // R9: status read
        log_n = 0; hi_group = 1'b0;
        do_read(wa(2'd2, 4'h9), d, lat);
        check("R9 status data", d, 8'hA5);
        check("R9 legacy read", {log_n[7:0], log_wr[0], log_addr[0]}, {8'd1, 1'b0, 16'h0008});
        check("R9 not early", {31'd0, (lat > 1)}, 1);

        // R12 + R11: stalled request, strobe ignored while busy
        lg_ready = 1'b0; log_n = 0;
        do_write(wa(2'd0, 4'h8), 8'h5E);
        @(negedge clk);
        held_a = leg_addr;
        reg_addr = wa(2'd0, 4'h0); reg_wdata = 8'hEE; reg_wr = 1'b1;
        repeat (3) @(negedge clk);
        reg_wr = 1'b0;
        check("R12 request held", {leg_valid, leg_addr, leg_wdata}, {1'b1, held_a, 8'h5E});
        check("R11 ready low while stalled", {31'd0, reg_ready}, 0);
        lg_ready = 1'b1;
        wait_idle();
        check("R12 single transfer", log_n, 1);
        do_read(wa(2'd0, 4'h0), d, lat);
        check("R11 ignored write", d, 8'h34);

        // R1: window decode
        win_base = 16'h127F;
        do_read(16'h1240, d, lat);
        check("R1 low base bits ignored", {lat[7:0], d}, {8'd1, 8'h34});
        do_write(16'h1280, 8'h66);
        wait_idle();
        do_read(wa(2'd0, 4'h0), d, lat);
        check("R1 miss write ignored", d, 8'h34);
        do_read(16'h1281, d, lat);
        check("R1 miss read silent", lat, 0);
        win_base = 16'h0000; log_n = 0;
        do_write(16'h0008, 8'h01);
        repeat (4) @(negedge clk);
        check("R1 zero base no request", log_n, 0);
        do_read(16'h0000, d, lat);
        check("R1 zero base no read", lat, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule